// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block holds the control logic of a word-wide parallel NOR flash, written as synchronous logic. The chip-enable, output-enable and write-enable strobes (all active low), a 16-bit address and a 16-bit data bus are sampled on a system clock. Keyed unlock write sequences are decoded into word program, sector erase, whole-array erase, and entry to and exit from an identification mode. Program and erase then run as internal operations, each timed by its own clock-count parameter. While one is running, reads return a status word instead of array data, and every new command write is ignored.

A small register array stands in for the cell array. A stored word is selected by a few low bits of the sector number (address bits 15..11) together with a few low row bits, so the array stays small. Its behaviour still follows the 2K-word sector boundary. Programming can only clear bits. Only an erase brings bits back to 1.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A bus write is active while ce_ni and we_ni are both low and oe_ni is high. The address is taken from the first sampled cycle of the active window. The data is taken from the last sampled cycle of the window. The write is acted on at the first clock edge after the window closes.
- R2: data_oe_o is high exactly when ce_ni and oe_ni are both low. Otherwise it is low.
- R3: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h, then a write of a target address and data, start a word program of that address.
- R4: A program stores the bitwise AND of the new data and the stored word, so a 0 bit stays 0 until an erase.
- R5: An internal operation stays busy for exactly T_PROG, T_SERASE or T_CERASE clock cycles. The count starts at the edge that acts on its final write.
- R6: While busy, a read returns a status word. Bit 7 is the complement of bit 7 of the programmed data for a program, and 0 for an erase. Bits 15..8 and 5..0 are 0.
- R7: While busy, status bit 6 is 0 on the first read after the operation starts and inverts after each completed read. When the operation ends, array data is returned again.
- R8: The writes 5555h/AAh, 2AAAh/55h, 5555h/90h enter identification mode. In that mode a read with address bit 0 at 0 returns 00BFh and a read with bit 0 at 1 returns 2788h. The mode is left either by a single write of F0h in the low byte to any address, or by 5555h/AAh, 2AAAh/55h, 5555h/F0h.
- R9: Command cycles compare only address bits 14..0 and data bits 7..0. Address bit 15 and data bits 15..8 are ignored, and the programmed word keeps all 16 bits.
- R10: A write inside a sequence that does not match the expected address and code abandons the sequence. No operation starts.
- R11: While busy, every write is ignored, including an identification exit.
- R12: The six writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then any address with 30h, set every stored word of that address's sector to FFFFh. Words of other sectors are left unchanged.
- R13: The same five writes followed by 5555h/10h set every stored word to FFFFh. After reset every stored word reads FFFFh.
- R14: A write strobe given while oe_ni is low is not a bus write and has no effect on the array or on sequence decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 16 | Word address |
| data_i | input | 16 | Write data |
| data_o | output | 16 | Read data or status word |
| data_oe_o | output | 1 | Drive enable for the data bus |

## Verification
Read data is combinational from registered state and the present address, so a read is sampled in the same cycle its strobes are applied. A write's effect is first visible in the cycle after the edge that follows the close of its write window. Busy lasts exactly the parameter count from that edge. A behavioural reference model advances on the same edges, and the bench compares data_oe_o and data_o against it on every clock, one nanosecond after the falling edge on which inputs change. Directed reads place one sample in the last busy cycle and one just after it, to pin down the end of the busy window.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_PROG, OP_SERASE, OP_CERASE
  } op_kind_e;

  typedef struct packed {
    op_kind_e    kind;
    logic [15:0] addr;
    logic [15:0] data;
  } op_req_t;

  localparam logic [14:0] KEY_ADDR_A   = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B   = 15'h2AAA;
  localparam logic [7:0]  CODE_UNLK_A  = 8'hAA;
  localparam logic [7:0]  CODE_UNLK_B  = 8'h55;
  localparam logic [7:0]  CODE_PROG    = 8'hA0;
  localparam logic [7:0]  CODE_ERASE   = 8'h80;
  localparam logic [7:0]  CODE_ID_IN   = 8'h90;
  localparam logic [7:0]  CODE_ID_OUT  = 8'hF0;
  localparam logic [7:0]  CODE_SECT    = 8'h30;
  localparam logic [7:0]  CODE_CHIP    = 8'h10;
  localparam logic [15:0] ID_MAKER     = 16'h00BF;
  localparam logic [15:0] ID_PART      = 16'h2788;

endpackage

// File: rtl/fcc_bus_front.sv
module fcc_bus_front (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_ni,
  input  logic        oe_ni,
  input  logic        we_ni,
  input  logic [15:0] addr_i,
  input  logic [15:0] data_i,
  output logic        wr_end_o,
  output logic [15:0] wr_addr_o,
  output logic [15:0] wr_data_o,
  output logic        rd_act_o,
  output logic        rd_end_o
);
  logic wr_act, wr_q, rd_q;
  logic [15:0] addr_q, data_q;

  // OE low inhibits writes
  assign wr_act   = ~ce_ni & ~we_ni & oe_ni;
  assign rd_act_o = ~ce_ni & ~oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act_o;
      if (wr_act && !wr_q) addr_q <= addr_i;
      if (wr_act)          data_q <= data_i;
    end
  end

  assign wr_end_o  = wr_q & ~wr_act;
  assign rd_end_o  = rd_q & ~rd_act_o;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import fcc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_end_i,
  input  logic [15:0] wr_addr_i,
  input  logic [15:0] wr_data_i,
  input  logic        busy_i,
  output logic        start_o,
  output op_req_t     op_o,
  output logic        id_mode_o
);
  seq_state_e state_q, state_d;
  logic       id_q, id_d;
  logic [14:0] key_a;
  logic [7:0]  key_d;

  assign key_a = wr_addr_i[14:0];
  assign key_d = wr_data_i[7:0];

  always_comb begin
    state_d   = state_q;
    id_d      = id_q;
    start_o   = 1'b0;
    op_o.kind = OP_PROG;
    op_o.addr = wr_addr_i;
    op_o.data = wr_data_i;
    if (wr_end_i && !busy_i) begin
      unique case (state_q)
        SQ_IDLE: begin
          if (key_a == KEY_ADDR_A && key_d == CODE_UNLK_A) state_d = SQ_U1;
          else if (key_d == CODE_ID_OUT)                   id_d = 1'b0;
        end
        SQ_U1:
          state_d = (key_a == KEY_ADDR_B && key_d == CODE_UNLK_B) ? SQ_U2 : SQ_IDLE;
        SQ_U2: begin
          state_d = SQ_IDLE;
          if (key_a == KEY_ADDR_A) begin
            unique case (key_d)
              CODE_PROG:   state_d = SQ_PGM;
              CODE_ERASE:  state_d = SQ_E3;
              CODE_ID_IN:  id_d = 1'b1;
              CODE_ID_OUT: id_d = 1'b0;
              default:     state_d = SQ_IDLE;
            endcase
          end
        end
        SQ_PGM: begin
          start_o = 1'b1;
          state_d = SQ_IDLE;
        end
        SQ_E3:
          state_d = (key_a == KEY_ADDR_A && key_d == CODE_UNLK_A) ? SQ_E4 : SQ_IDLE;
        SQ_E4:
          state_d = (key_a == KEY_ADDR_B && key_d == CODE_UNLK_B) ? SQ_E5 : SQ_IDLE;
        SQ_E5: begin
          state_d = SQ_IDLE;
          if (key_d == CODE_SECT) begin
            start_o   = 1'b1;
            op_o.kind = OP_SERASE;
          end else if (key_a == KEY_ADDR_A && key_d == CODE_CHIP) begin
            start_o   = 1'b1;
            op_o.kind = OP_CERASE;
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
    end
  end

  assign id_mode_o = id_q;
endmodule

// File: rtl/fcc_timer.sv
module fcc_timer
  import fcc_pkg::*;
#(
  parameter int T_PROG   = 14,
  parameter int T_SERASE = 200,
  parameter int T_CERASE = 400
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  op_req_t     op_i,
  input  logic        rd_end_i,
  output logic        busy_o,
  output logic        tog_o,
  output logic [15:0] stat_o
);
  localparam int T_AB  = (T_PROG > T_SERASE) ? T_PROG : T_SERASE;
  localparam int T_MAX = (T_AB > T_CERASE) ? T_AB : T_CERASE;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt_q, load_val;
  logic busy_q, tog_q, dq7_q;
  logic unused_bits;

  assign unused_bits = ^{op_i.addr, op_i.data[15:8], op_i.data[6:0]};

  always_comb begin
    unique case (op_i.kind)
      OP_SERASE: load_val = CNT_W'(T_SERASE - 1);
      OP_CERASE: load_val = CNT_W'(T_CERASE - 1);
      default:   load_val = CNT_W'(T_PROG - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tog_q  <= 1'b0;
      dq7_q  <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
      tog_q  <= 1'b0;
      dq7_q  <= (op_i.kind == OP_PROG) ? ~op_i.data[7] : 1'b0;
    end else if (busy_q) begin
      if (rd_end_i) tog_q <= ~tog_q;
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign tog_o  = tog_q;
  assign stat_o = {8'h00, dq7_q, tog_q, 6'h00};
endmodule

// File: rtl/fcc_array.sv
module fcc_array
  import fcc_pkg::*;
#(
  parameter int SECT_LSB   = 11,
  parameter int SECT_SEL_W = 2,
  parameter int ROW_W      = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  op_req_t     op_i,
  input  logic [15:0] rd_addr_i,
  output logic [15:0] rd_data_o
);
  localparam int IDX_W = SECT_SEL_W + ROW_W;
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] word_idx(input logic [15:0] a);
    return {a[SECT_LSB+SECT_SEL_W-1:SECT_LSB], a[ROW_W-1:0]};
  endfunction

  logic [15:0] words [DEPTH];
  logic [IDX_W-1:0] op_idx;
  logic unused_bits;

  assign op_idx      = word_idx(op_i.addr);
  assign unused_bits = ^{op_i.addr, rd_addr_i};

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    logic [15:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '1;
      end else if (start_i) begin
        unique case (op_i.kind)
          OP_PROG:   if (op_idx == GI) word_q <= word_q & op_i.data;
          OP_SERASE: if (op_idx[IDX_W-1:ROW_W] == GI[IDX_W-1:ROW_W]) word_q <= '1;
          default:   word_q <= '1;
        endcase
      end
    end
    assign words[g] = word_q;
  end

  assign rd_data_o = words[word_idx(rd_addr_i)];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int SECT_LSB   = 11,
  parameter int SECT_SEL_W = 2,
  parameter int ROW_W      = 4,
  parameter int T_PROG     = 14,
  parameter int T_SERASE   = 200,
  parameter int T_CERASE   = 400
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_ni,
  input  logic        oe_ni,
  input  logic        we_ni,
  input  logic [15:0] addr_i,
  input  logic [15:0] data_i,
  output logic [15:0] data_o,
  output logic        data_oe_o
);
  logic        wr_end, rd_act, rd_end, busy, tog, id_mode, op_start;
  logic [15:0] wr_addr, wr_data, stat_word, arr_data;
  op_req_t     op_req;

  fcc_bus_front u_front (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .data_i,
    .wr_end_o(wr_end), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_act_o(rd_act), .rd_end_o(rd_end)
  );

  fcc_seq u_seq (
    .clk_i, .rst_ni, .wr_end_i(wr_end), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .busy_i(busy), .start_o(op_start), .op_o(op_req), .id_mode_o(id_mode)
  );

  fcc_timer #(.T_PROG(T_PROG), .T_SERASE(T_SERASE), .T_CERASE(T_CERASE)) u_timer (
    .clk_i, .rst_ni, .start_i(op_start), .op_i(op_req), .rd_end_i(rd_end),
    .busy_o(busy), .tog_o(tog), .stat_o(stat_word)
  );

  fcc_array #(.SECT_LSB(SECT_LSB), .SECT_SEL_W(SECT_SEL_W), .ROW_W(ROW_W)) u_array (
    .clk_i, .rst_ni, .start_i(op_start), .op_i(op_req),
    .rd_addr_i(addr_i), .rd_data_o(arr_data)
  );

  // status has priority over ID and array data
  always_comb begin
    if (busy)         data_o = stat_word;
    else if (id_mode) data_o = addr_i[0] ? ID_PART : ID_MAKER;
    else              data_o = arr_data;
  end

  assign data_oe_o = rd_act;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        oe_ni,
  input logic        addr0_i,
  input logic        data_oe_i,
  input logic [15:0] data_i,
  input logic        busy_i,
  input logic        start_i,
  input logic        tog_i,
  input logic        id_mode_i,
  input logic        rd_end_i
);
  // R2
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_i);

  // R5
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_i);

  // R6
  stat_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && data_oe_i) |-> (data_i[15:8] == 8'h00 && data_i[5:0] == 6'h00));

  // R7
  tog_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_end_i) |=> (tog_i != $past(tog_i)));

  // R11
  id_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(id_mode_i));

  // R8
  id_maker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_i && !busy_i && data_oe_i && !addr0_i) |-> data_i == 16'h00BF);
endmodule

bind flash_cmd_ctrl fcc_checker u_fcc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .oe_ni(oe_ni), .addr0_i(addr_i[0]),
  .data_oe_i(data_oe_o), .data_i(data_o), .busy_i(busy), .start_i(op_start),
  .tog_i(tog), .id_mode_i(id_mode), .rd_end_i(rd_end)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int TP = 12, TS = 16, TC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b1, oe = 1'b1, we = 1'b1;
  logic [15:0] addr = '0, din = '0;
  logic [15:0] dout;
  logic doe;
  int n_chk = 0, n_err = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.T_PROG(TP), .T_SERASE(TS), .T_CERASE(TC)) u_flash_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce), .oe_ni(oe), .we_ni(we),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  // reference model
  int m_st, m_busy;
  bit m_id, m_tog, m_dq7, m_wp, m_rp;
  logic [15:0] m_a, m_d;
  logic [15:0] mem [64];

  function automatic int midx(input logic [15:0] a);
    return int'({a[12:11], a[3:0]});
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit wr, rd, we_end, re_end;
    if (!rst_n) begin
      m_st = 0; m_busy = 0; m_id = 0; m_tog = 0; m_dq7 = 0; m_wp = 0; m_rp = 0;
      m_a = '0; m_d = '0;
      foreach (mem[i]) mem[i] = 16'hFFFF;
    end else begin
      wr = !ce && !we && oe;
      rd = !ce && !oe;
      if (wr && !m_wp) m_a = addr;
      if (wr) m_d = din;
      we_end = m_wp && !wr;
      re_end = m_rp && !rd;
      if (m_busy > 0) begin
        if (re_end) m_tog = !m_tog;
        m_busy--;
      end else if (we_end) begin
        case (m_st)
          0: if (m_a[14:0] == 15'h5555 && m_d[7:0] == 8'hAA) m_st = 1;
             else if (m_d[7:0] == 8'hF0) m_id = 0;
          1: m_st = (m_a[14:0] == 15'h2AAA && m_d[7:0] == 8'h55) ? 2 : 0;
          2: begin
            m_st = 0;
            if (m_a[14:0] == 15'h5555) begin
              if (m_d[7:0] == 8'hA0) m_st = 3;
              else if (m_d[7:0] == 8'h80) m_st = 4;
              else if (m_d[7:0] == 8'h90) m_id = 1;
              else if (m_d[7:0] == 8'hF0) m_id = 0;
            end
          end
          3: begin
            mem[midx(m_a)] = mem[midx(m_a)] & m_d;
            m_busy = TP; m_dq7 = !m_d[7]; m_tog = 0; m_st = 0;
          end
          4: m_st = (m_a[14:0] == 15'h5555 && m_d[7:0] == 8'hAA) ? 5 : 0;
          5: m_st = (m_a[14:0] == 15'h2AAA && m_d[7:0] == 8'h55) ? 6 : 0;
          6: begin
            m_st = 0;
            if (m_d[7:0] == 8'h30) begin
              for (int i = 0; i < 64; i++)
                if ((i >> 4) == int'(m_a[12:11])) mem[i] = 16'hFFFF;
              m_busy = TS; m_dq7 = 0; m_tog = 0;
            end else if (m_a[14:0] == 15'h5555 && m_d[7:0] == 8'h10) begin
              foreach (mem[i]) mem[i] = 16'hFFFF;
              m_busy = TC; m_dq7 = 0; m_tog = 0;
            end
          end
          default: m_st = 0;
        endcase
      end
      m_wp = wr;
      m_rp = rd;
    end
  end

  // per-cycle compare against the model
  always @(negedge clk) begin
    logic [15:0] exp_d;
    #1;
    if (rst_n && !done) begin
      n_chk++;
      if (doe !== (!ce && !oe)) begin
        n_err++;
        $display("FAIL R2: data_oe_o got %b expected %b", doe, (!ce && !oe));
      end
      if (!ce && !oe) begin
        if (m_busy > 0)  exp_d = {8'h00, m_dq7, m_tog, 6'h00};
        else if (m_id)   exp_d = addr[0] ? 16'h2788 : 16'h00BF;
        else             exp_d = mem[midx(addr)];
        n_chk++;
        if (dout !== exp_d) begin
          n_err++;
          $display("FAIL %s: data_o got %h expected %h",
                   (m_busy > 0) ? "R6" : (m_id ? "R8" : "R3"), dout, exp_d);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; ce = 1'b0; we = 1'b0;
    @(negedge clk); we = 1'b1; ce = 1'b1;
  endtask

  task automatic bus_wr_oe_low(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; ce = 1'b0; we = 1'b0; oe = 1'b0;
    @(negedge clk); we = 1'b1; ce = 1'b1; oe = 1'b1;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [15:0] q);
    @(negedge clk); addr = a; ce = 1'b0; oe = 1'b0;
    #1 q = dout;
    @(negedge clk); oe = 1'b1; ce = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d);
    bus_wr(16'h5555, 16'h00AA); bus_wr(16'h2AAA, 16'h0055);
    bus_wr(16'h5555, 16'h00A0); bus_wr(a, d);
  endtask

  task automatic erase_pre();
    bus_wr(16'h5555, 16'h00AA); bus_wr(16'h2AAA, 16'h0055); bus_wr(16'h5555, 16'h0080);
    bus_wr(16'h5555, 16'h00AA); bus_wr(16'h2AAA, 16'h0055);
  endtask

  task automatic id_enter();
    bus_wr(16'h5555, 16'h00AA); bus_wr(16'h2AAA, 16'h0055); bus_wr(16'h5555, 16'h0090);
  endtask

  initial begin : watchdog
    #(4 * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] q;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R13 reset state
    bus_rd(16'h0000, q); chk("R13 reset", q, 16'hFFFF);
    @(negedge clk); ce = 1'b0; #1 chk("R2 oe high", {15'h0, doe}, 16'h0000);
    @(negedge clk); ce = 1'b1;

    // R3 / R6 / R7
    prog(16'h0003, 16'h1234);
    bus_rd(16'h0003, q); chk("R6 prog dq7", q, 16'h0080);
    bus_rd(16'h0003, q); chk("R7 toggle 1", q, 16'h00C0);
    bus_rd(16'h0003, q); chk("R7 toggle 2", q, 16'h0080);
    idle(TP + 3);
    bus_rd(16'h0003, q); chk("R3 programmed", q, 16'h1234);

    // R5 busy boundary, R4 AND
    prog(16'h0003, 16'hFF0F);
    idle(TP - 1);
    bus_rd(16'h0003, q); chk("R5 last busy cycle", q, 16'h0080);
    bus_rd(16'h0003, q); chk("R5 R4 after busy", q, 16'h1204);

    // R9 don't-care bits
    bus_wr(16'hD555, 16'h33AA); bus_wr(16'hAAAA, 16'hFF55);
    bus_wr(16'h5555, 16'hFFA0); bus_wr(16'h0805, 16'h5A5A);
    idle(TP + 3);
    bus_rd(16'h0805, q); chk("R9 masked keys", q, 16'h5A5A);

    // R1 address from first active cycle, data from last
    @(negedge clk); addr = 16'h0000; din = 16'h0000; ce = 1'b0;
    @(negedge clk); addr = 16'h5555; din = 16'h0011; we = 1'b0;
    @(negedge clk); addr = 16'h0000; din = 16'h00AA;
    @(negedge clk); we = 1'b1; ce = 1'b1;
    bus_wr(16'h2AAA, 16'h0055); bus_wr(16'h5555, 16'h00A0); bus_wr(16'h0007, 16'h00F0);
    idle(TP + 3);
    bus_rd(16'h0007, q); chk("R1 latch timing", q, 16'h00F0);

    // R10 abort
    bus_wr(16'h5555, 16'h00AA); bus_wr(16'h2AAA, 16'h0056);
    bus_wr(16'h5555, 16'h00A0); bus_wr(16'h0006, 16'h0000);
    idle(TP + 3);
    bus_rd(16'h0006, q); chk("R10 abort", q, 16'hFFFF);

    // R8 ID mode
    id_enter();
    bus_rd(16'h0000, q); chk("R8 maker", q, 16'h00BF);
    bus_rd(16'h1235, q); chk("R8 part", q, 16'h2788);
    bus_wr(16'h0000, 16'h00F0);
    bus_rd(16'h0003, q); chk("R8 single exit", q, 16'h1204);
    id_enter();
    bus_rd(16'h0001, q); chk("R8 reenter", q, 16'h2788);
    bus_wr(16'h5555, 16'h00AA); bus_wr(16'h2AAA, 16'h0055); bus_wr(16'h5555, 16'h00F0);
    bus_rd(16'h0003, q); chk("R8 long exit", q, 16'h1204);

    // R11 exit ignored while busy
    id_enter();
    prog(16'h0008, 16'h0000);
    bus_wr(16'h0000, 16'h00F0);
    idle(TP + 3);
    bus_rd(16'h0000, q); chk("R11 id held", q, 16'h00BF);
    bus_wr(16'h0000, 16'h00F0);
    bus_rd(16'h0008, q); chk("R3 prog in id", q, 16'h0000);

    // R6 dq7 for data bit 7 set
    prog(16'h000C, 16'h00FF);
    bus_rd(16'h000C, q); chk("R6 dq7 low", q, 16'h0000);
    idle(TP + 3);

    // R12 sector erase, R11 program ignored during erase
    prog(16'h0803, 16'h0000);
    idle(TP + 3);
    erase_pre(); bus_wr(16'h0800, 16'h0030);
    bus_rd(16'h0003, q); chk("R6 erase dq7", q, 16'h0000);
    bus_rd(16'h0003, q); chk("R7 erase toggle", q, 16'h0040);
    prog(16'h000A, 16'h0000);
    idle(TS + 3);
    bus_rd(16'h0803, q); chk("R12 sector word", q, 16'hFFFF);
    bus_rd(16'h0805, q); chk("R12 sector word 2", q, 16'hFFFF);
    bus_rd(16'h0003, q); chk("R12 other sector", q, 16'h1204);
    bus_rd(16'h000A, q); chk("R11 ignored prog", q, 16'hFFFF);

    // R14 write inhibit with OE low
    bus_wr_oe_low(16'h5555, 16'h00AA); bus_wr_oe_low(16'h2AAA, 16'h0055);
    bus_wr_oe_low(16'h5555, 16'h00A0);
    bus_wr(16'h0003, 16'h0000);
    idle(TP + 3);
    bus_rd(16'h0003, q); chk("R14 inhibit", q, 16'h1204);

    // R13 chip erase
    erase_pre(); bus_wr(16'h5555, 16'h0010);
    idle(TC - 1);
    bus_rd(16'h0003, q); chk("R5 chip last busy", q, 16'h0000);
    bus_rd(16'h0003, q); chk("R13 chip erase", q, 16'hFFFF);
    bus_rd(16'h0008, q); chk("R13 chip erase 2", q, 16'hFFFF);

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule